// File: doc/BRIEF.md
# Palette Lookup with Colour Rotation

This block turns a stream of 8-bit palette indices into 12-bit RGB pixels. The colour table is not held inside the block. It lives in shared video RAM, starting at a byte address that software can move at any time. For each accepted index the block issues one read of a 16-bit word from video RAM. After a fixed two-cycle read latency, it presents the low 12 bits of that word as the pixel colour. Pixels come out in the order they went in, and the block never stalls.

Software can also pick a contiguous window of palette entries and let the block rotate it on its own. Rotation is set by an inclusive first index, an inclusive last index, an enable bit and a frame divider. A phase counter steps once per programmed number of vertical-sync strobes. Every index inside the window is then remapped by that phase, modulo the window length. Because each colour is fetched from RAM when its pixel is accepted, two kinds of change made in the middle of a frame reach the very next pixels: a new base address, and new palette contents.

Top module: `clut_rotator`

## Requirements
- R1: After a synchronous active-high reset, rgb_valid is 0 and rgb is 0. The base address is 0, rotation is disabled, the frame divider is 1 and the phase is 0.
- R2: An accepted index i reads the video RAM word at byte address (base + 2*e) modulo 2^17, where e is the effective index. rgb equals bits 11:0 of that word, laid out as red 11:8, green 7:4 and blue 3:0. Bits 15:12 of the word are discarded.
- R3: rgb_valid equals pix_valid delayed by exactly two cycles, with no stalls and with order kept. While rgb_valid is 0, rgb is 0.
- R4: A configuration write is performed when cfg_we is high, and cfg_sel chooses the target. Select 0 loads the base address from cfg_wdata[16:0], with bit 0 forced to 0. Select 1 loads the window: first index in cfg_wdata[7:0], last index in cfg_wdata[15:8] and enable in cfg_wdata[16]. Select 2 loads the frame divider from cfg_wdata[7:0]. A write with select 3 changes nothing.
- R5: A base write or a palette content change takes effect for the first pixel accepted in a later cycle. A pixel accepted in the same cycle as a base write uses the old base.
- R6: When rotation is active and first ≤ i ≤ last, the effective index is first + ((i − first + phase) mod (last − first + 1)).
- R7: When rotation is disabled, or when first > last, every index passes through unchanged. Indices outside the window always pass through unchanged.
- R8: While rotation is active, a vsync strobe increments a frame count. When that count reaches the divider (a divider of 0 acts as 1), the count returns to 0 and the phase advances by one, wrapping to 0 at the window length.
- R9: A window write clears both the phase and the frame count. A divider write clears the frame count. A vsync strobe in the same cycle as either write is not counted.
- R10: While rotation is inactive, vsync strobes leave the phase unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_valid | input | 1 | Index on pix_idx is accepted this cycle |
| pix_idx | input | 8 | Palette index |
| vsync | input | 1 | One-cycle frame strobe |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Configuration target: 0 base, 1 window, 2 divider, 3 none |
| cfg_wdata | input | 17 | Configuration write data |
| vram_rd_en | output | 1 | Video RAM read request |
| vram_rd_addr | output | 17 | Video RAM byte address, even |
| vram_rd_data | input | 16 | Read data, valid two cycles after the request |
| rgb_valid | output | 1 | rgb carries a pixel |
| rgb | output | 12 | Pixel colour, R 11:8, G 7:4, B 3:0 |

## Verification
The hardest state to reach from the ports is a rotation phase near the end of a long window, close to its wrap point. Reaching it takes hundreds of vsync strobes with the window held constant, and any window write in between silently clears it. The stimulus therefore holds a full 256-entry window with a divider of 1 for more than 256 frames, probing indices 0 and 255 along the way. A further directed sequence lands vsync strobes in the same cycles as window and divider writes. The random part mixes sparse writes with frequent strobes, so that shorter windows often wrap between writes.

// File: rtl/clut_pkg.sv
package clut_pkg;
   typedef enum logic [1:0] {
      SEL_BASE  = 2'd0,
      SEL_RANGE = 2'd1,
      SEL_RATE  = 2'd2,
      SEL_NONE  = 2'd3
   } cfg_sel_e;
endpackage

// File: rtl/clut_phase.sv
module clut_phase #(
   parameter int IDX_W  = 8,
   parameter int RATE_W = 8,
   localparam int SPAN_W = IDX_W + 1,
   localparam int RC_W   = RATE_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              range_we,
   input  logic              rate_we,
   input  logic [IDX_W-1:0]  new_first,
   input  logic [IDX_W-1:0]  new_last,
   input  logic              new_en,
   input  logic [RATE_W-1:0] new_rate,
   input  logic              vsync,
   output logic [IDX_W-1:0]  first_o,
   output logic [IDX_W-1:0]  last_o,
   output logic              active_o,
   output logic [SPAN_W-1:0] span_o,
   output logic [IDX_W-1:0]  phase_o
);
   logic [IDX_W-1:0]  first_q, last_q, ph_q;
   logic              en_q;
   logic [RATE_W-1:0] rate_q, fcnt_q, rate_eff;
   logic [RC_W-1:0]   fnext;
   logic [SPAN_W-1:0] pinc;
   logic              frame_done, count_ok;

   assign active_o   = en_q && (first_q <= last_q);
   assign span_o     = SPAN_W'(last_q) - SPAN_W'(first_q) + SPAN_W'(1);
   assign rate_eff   = (rate_q == '0) ? RATE_W'(1) : rate_q;
   assign fnext      = RC_W'(fcnt_q) + RC_W'(1);
   assign frame_done = fnext >= RC_W'(rate_eff);
   assign pinc       = SPAN_W'(ph_q) + SPAN_W'(1);
   assign count_ok   = vsync && active_o && !range_we && !rate_we;

   always_ff @(posedge clk) begin
      if (rst) begin
         first_q <= '0;
         last_q  <= '0;
         en_q    <= 1'b0;
         rate_q  <= RATE_W'(1);
         fcnt_q  <= '0;
         ph_q    <= '0;
      end else begin
         if (range_we) begin
            first_q <= new_first;
            last_q  <= new_last;
            en_q    <= new_en;
            ph_q    <= '0;
            fcnt_q  <= '0;
         end
         if (rate_we) begin
            rate_q <= new_rate;
            fcnt_q <= '0;
         end
         if (count_ok) begin
            if (frame_done) begin
               fcnt_q <= '0;
               ph_q   <= (pinc == span_o) ? '0 : pinc[IDX_W-1:0];
            end else begin
               fcnt_q <= fnext[RATE_W-1:0];
            end
         end
      end
   end

   assign first_o = first_q;
   assign last_o  = last_q;
   assign phase_o = ph_q;

   p_phase_bound_r8: assert property (@(posedge clk) disable iff (rst)
      active_o |-> (SPAN_W'(ph_q) < span_o));
   p_step_wait_r8: assert property (@(posedge clk) disable iff (rst)
      (count_ok && !frame_done) |=> $stable(ph_q));
   p_phase_clear_r9: assert property (@(posedge clk) disable iff (rst)
      range_we |=> (ph_q == '0));
   p_phase_hold_r10: assert property (@(posedge clk) disable iff (rst)
      (!active_o && !range_we) |=> $stable(ph_q));
endmodule

// File: rtl/clut_remap.sv
module clut_remap #(
   parameter int IDX_W = 8,
   localparam int SPAN_W = IDX_W + 1
) (
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [IDX_W-1:0]  first_i,
   input  logic [IDX_W-1:0]  last_i,
   input  logic              active_i,
   input  logic [SPAN_W-1:0] span_i,
   input  logic [IDX_W-1:0]  phase_i,
   output logic [IDX_W-1:0]  eff_o
);
   logic              in_rng;
   logic [IDX_W-1:0]  off;
   logic [SPAN_W-1:0] sum, wrapped;

   always_comb begin
      in_rng  = active_i && (idx_i >= first_i) && (idx_i <= last_i);
      off     = idx_i - first_i;
      sum     = SPAN_W'(off) + SPAN_W'(phase_i);
      wrapped = (sum >= span_i) ? (sum - span_i) : sum;
      eff_o   = in_rng ? (first_i + wrapped[IDX_W-1:0]) : idx_i;
      if (in_rng && (SPAN_W'(phase_i) < span_i)) begin
         p_stay_in_range_r6: assert ((eff_o >= first_i) && (eff_o <= last_i));
      end
   end
endmodule

// File: rtl/clut_rotator.sv
module clut_rotator
   import clut_pkg::*;
#(
   parameter int IDX_W  = 8,
   parameter int ADDR_W = 17,
   parameter int COL_W  = 12,
   parameter int WORD_W = 16,
   parameter int RATE_W = 8,
   parameter int RD_LAT = 2,
   localparam int CFG_W  = (ADDR_W > 2*IDX_W + 1) ? ADDR_W : 2*IDX_W + 1,
   localparam int SPAN_W = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pix_valid,
   input  logic [IDX_W-1:0]  pix_idx,
   input  logic              vsync,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic              vram_rd_en,
   output logic [ADDR_W-1:0] vram_rd_addr,
   input  logic [WORD_W-1:0] vram_rd_data,
   output logic              rgb_valid,
   output logic [COL_W-1:0]  rgb
);
   initial begin
      if (RD_LAT < 1 || RD_LAT > 8) $fatal(1, "RD_LAT out of range");
      if (ADDR_W <= IDX_W + 1)      $fatal(1, "ADDR_W too small for palette");
      if (COL_W > WORD_W)           $fatal(1, "COL_W wider than WORD_W");
      if (RATE_W > CFG_W)           $fatal(1, "RATE_W wider than write data");
   end

   cfg_sel_e          sel_e;
   logic              base_we, range_we, rate_we;
   logic [ADDR_W-1:0] base_q;
   logic [IDX_W-1:0]  first_w, last_w, phase_w, eff_idx;
   logic              active_w;
   logic [SPAN_W-1:0] span_w;
   logic [RD_LAT-1:0] vpipe;

   assign sel_e    = cfg_sel_e'(cfg_sel);
   assign base_we  = cfg_we && (sel_e == SEL_BASE);
   assign range_we = cfg_we && (sel_e == SEL_RANGE);
   assign rate_we  = cfg_we && (sel_e == SEL_RATE);

   always_ff @(posedge clk) begin
      if (rst)          base_q <= '0;
      else if (base_we) base_q <= {cfg_wdata[ADDR_W-1:1], 1'b0};
   end

   clut_phase #(.IDX_W(IDX_W), .RATE_W(RATE_W)) u_phase (
      .clk      (clk),
      .rst      (rst),
      .range_we (range_we),
      .rate_we  (rate_we),
      .new_first(cfg_wdata[IDX_W-1:0]),
      .new_last (cfg_wdata[2*IDX_W-1:IDX_W]),
      .new_en   (cfg_wdata[2*IDX_W]),
      .new_rate (cfg_wdata[RATE_W-1:0]),
      .vsync    (vsync),
      .first_o  (first_w),
      .last_o   (last_w),
      .active_o (active_w),
      .span_o   (span_w),
      .phase_o  (phase_w)
   );

   clut_remap #(.IDX_W(IDX_W)) u_remap (
      .idx_i   (pix_idx),
      .first_i (first_w),
      .last_i  (last_w),
      .active_i(active_w),
      .span_i  (span_w),
      .phase_i (phase_w),
      .eff_o   (eff_idx)
   );

   assign vram_rd_en   = pix_valid;
   assign vram_rd_addr = base_q + ADDR_W'({eff_idx, 1'b0});

   generate
      if (RD_LAT == 1) begin : g_lat_one
         always_ff @(posedge clk) begin
            if (rst) vpipe <= '0;
            else     vpipe <= pix_valid;
         end
      end else begin : g_lat_multi
         always_ff @(posedge clk) begin
            if (rst) vpipe <= '0;
            else     vpipe <= {vpipe[RD_LAT-2:0], pix_valid};
         end
      end
   endgenerate

   assign rgb_valid = vpipe[RD_LAT-1];
   assign rgb       = rgb_valid ? vram_rd_data[COL_W-1:0] : '0;

   logic [3:0] age_q;
   always_ff @(posedge clk) begin
      if (rst)                 age_q <= '0;
      else if (age_q < RD_LAT) age_q <= age_q + 4'd1;
   end

   p_valid_latency_r3: assert property (@(posedge clk) disable iff (rst)
      (age_q >= RD_LAT) |-> (rgb_valid == $past(pix_valid, RD_LAT)));
   p_addr_even_r2: assert property (@(posedge clk) disable iff (rst)
      vram_rd_en |-> (vram_rd_addr[0] == 1'b0));
   p_base_load_r4: assert property (@(posedge clk) disable iff (rst)
      base_we |=> (base_q == {$past(cfg_wdata[ADDR_W-1:1]), 1'b0}));
endmodule

// File: tb/sim_clut_rotator.sv
module sim_clut_rotator;
   logic        clk = 1'b0;
   logic        rst;
   logic        pix_valid, vsync, cfg_we;
   logic [7:0]  pix_idx;
   logic [1:0]  cfg_sel;
   logic [16:0] cfg_wdata;
   logic        vram_rd_en;
   logic [16:0] vram_rd_addr;
   logic [15:0] vram_rd_data;
   logic        rgb_valid;
   logic [11:0] rgb;

   always #5 clk = ~clk;

   clut_rotator u0 (
      .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_idx(pix_idx),
      .vsync(vsync), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .vram_rd_en(vram_rd_en), .vram_rd_addr(vram_rd_addr),
      .vram_rd_data(vram_rd_data), .rgb_valid(rgb_valid), .rgb(rgb)
   );

   logic [7:0]  salt = 8'h00;
   logic [15:0] m1, m2;

   function automatic logic [15:0] vram_word(input logic [16:0] a, input logic [7:0] s);
      return {a[4:1] ^ 4'h5, a[12:1] ^ {s, a[16:13]}};
   endfunction

   always @(posedge clk) begin
      m1 <= vram_rd_en ? vram_word(vram_rd_addr, salt) : 16'hFFFF;
      m2 <= m1;
   end
   assign vram_rd_data = m2;

   int    n_chk = 0, n_fail = 0;
   bit    done = 0;
   bit    pv0 = 0, pv1 = 0;
   logic [11:0] pr0 = '0, pr1 = '0;
   string pq0 = "R1", pq1 = "R1";

   int m_base, m_first, m_last, m_en, m_rate, m_fcnt, m_phase;

   function automatic bit m_active();
      return (m_en != 0) && (m_first <= m_last);
   endfunction

   function automatic int exp_index(input int idx);
      int span;
      if (m_active() && idx >= m_first && idx <= m_last) begin
         span = m_last - m_first + 1;
         return m_first + ((idx - m_first + m_phase) % span);
      end
      return idx;
   endfunction

   task automatic cyc(input bit v, input int idx, input bit vs, input bit we,
                      input int sel, input int wd, input string req);
      int e, a, span, re;
      logic [15:0] w;
      n_chk++;
      if (pv1) begin
         if (!(rgb_valid === 1'b1 && rgb === pr1)) begin
            n_fail++;
            $display("FAIL %s: valid/rgb got %b/%h expected 1/%h", pq1, rgb_valid, rgb, pr1);
         end
      end else if (!(rgb_valid === 1'b0 && rgb === 12'h000)) begin
         n_fail++;
         $display("FAIL %s: valid/rgb got %b/%h expected 0/000", pq1, rgb_valid, rgb);
      end
      pix_valid = v; pix_idx = idx[7:0]; vsync = vs;
      cfg_we = we; cfg_sel = sel[1:0]; cfg_wdata = wd[16:0];
      e = exp_index(idx[7:0]);
      a = (m_base + 2 * e) & 32'h1FFFF;
      w = vram_word(a[16:0], salt);
      pv1 = pv0; pr1 = pr0; pq1 = pq0;
      pv0 = v;   pr0 = w[11:0]; pq0 = req;
      if (we && sel == 0) m_base = wd & 32'h1FFFE;
      if (we && sel == 1) begin
         m_first = wd & 255; m_last = (wd >> 8) & 255; m_en = (wd >> 16) & 1;
         m_phase = 0; m_fcnt = 0;
      end
      if (we && sel == 2) begin m_rate = wd & 255; m_fcnt = 0; end
      if (vs && m_active() && !(we && (sel == 1 || sel == 2))) begin
         re = (m_rate == 0) ? 1 : m_rate;
         span = m_last - m_first + 1;
         if (m_fcnt + 1 >= re) begin
            m_fcnt = 0;
            m_phase = (m_phase + 1 == span) ? 0 : m_phase + 1;
         end else m_fcnt++;
      end
      @(negedge clk);
   endtask

   task automatic pix(input int idx, input string req);
      cyc(1, idx, 0, 0, 0, 0, req);
   endtask

   task automatic wr(input int sel, input int wd, input string req);
      cyc(0, 0, 0, 1, sel, wd, req);
   endtask

   function automatic int rng(input int f, input int l, input int en);
      return (en << 16) | (l << 8) | f;
   endfunction

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not complete");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst = 1; pix_valid = 0; pix_idx = 0; vsync = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
      m_base = 0; m_first = 0; m_last = 0; m_en = 0; m_rate = 1; m_fcnt = 0; m_phase = 0;
      repeat (3) @(negedge clk);
      rst = 0;
      // R1: idle outputs and default identity lookup from base 0
      cyc(0, 0, 0, 0, 0, 0, "R1");
      cyc(0, 0, 1, 0, 0, 0, "R1");
      pix(5, "R1"); pix(200, "R1");
      // R2: lookup and address wrap modulo 2^17; R4: bit 0 of base ignored
      pix(0, "R2"); pix(255, "R2"); pix(128, "R2");
      wr(0, 17'h1FF01, "R4");
      pix(255, "R2"); pix(127, "R2"); pix(0, "R2");
      // R4: select 3 writes are ignored
      wr(3, 17'h1FFFF, "R4");
      pix(255, "R4"); pix(1, "R4");
      // R5: base change in the same cycle as a pixel, then next pixel
      cyc(1, 7, 0, 1, 0, 17'h04000, "R5");
      pix(7, "R5");
      salt = 8'h3C;
      pix(7, "R5"); pix(9, "R5");
      // R3: gaps in valid
      for (int i = 0; i < 12; i++) cyc(i % 3 != 0, i * 17, 0, 0, 0, 0, "R3");
      // R6/R8: window 10..13, divider 2
      wr(1, rng(10, 13, 1), "R6");
      wr(2, 2, "R8");
      for (int f = 0; f < 10; f++) begin
         for (int i = 8; i < 16; i++) pix(i, "R6");
         cyc(0, 0, 1, 0, 0, 0, "R8");
      end
      // R8: divider 0 acts as 1
      wr(2, 0, "R8");
      for (int f = 0; f < 6; f++) begin cyc(1, 10, 1, 0, 0, 0, "R8"); pix(13, "R8"); end
      // R7: first > last disables remapping
      wr(1, rng(20, 5, 1), "R7");
      for (int f = 0; f < 4; f++) begin cyc(1, 10, 1, 0, 0, 0, "R7"); pix(20, "R7"); end
      // R7/R10: disabled window, vsyncs leave phase alone
      wr(1, rng(0, 255, 0), "R10");
      for (int f = 0; f < 5; f++) begin cyc(1, 3, 1, 0, 0, 0, "R10"); pix(250, "R7"); end
      // R8: full window, divider 1, run past the wrap
      wr(2, 1, "R8");
      wr(1, rng(0, 255, 1), "R8");
      for (int f = 0; f < 300; f++) begin
         cyc(1, 0, 1, 0, 0, 0, "R8");
         pix(255, "R8");
      end
      // R9: vsync coinciding with window and divider writes
      wr(1, rng(30, 33, 1), "R9");
      cyc(0, 0, 1, 0, 0, 0, "R9");
      pix(30, "R9");
      cyc(1, 30, 1, 1, 1, rng(30, 33, 1), "R9");
      pix(30, "R9"); pix(31, "R9");
      wr(2, 3, "R9");
      cyc(0, 0, 1, 0, 0, 0, "R9"); cyc(0, 0, 1, 0, 0, 0, "R9");
      cyc(1, 30, 1, 1, 2, 3, "R9");
      pix(30, "R9");
      for (int f = 0; f < 3; f++) cyc(1, 32, 1, 0, 0, 0, "R9");
      pix(30, "R9");
      // random mix
      for (int n = 0; n < 4000; n++) begin
         int r, sel, wd;
         bit we;
         r = $urandom;
         we = ($urandom % 40) == 0;
         sel = $urandom % 4;
         if (sel == 1) wd = rng($urandom % 256, $urandom % 256, ($urandom % 4) != 0);
         else if (sel == 2) wd = $urandom % 5;
         else wd = $urandom & 32'h1FFFF;
         if ((r & 255) == 7) salt = salt + 8'h11;
         cyc((r & 3) != 0, ($urandom % 4 == 0) ? m_first + ($urandom % 4) : ($urandom % 256),
             ((r >> 4) % 6) == 0, we, sel, wd, "R6");
      end
      cyc(0, 0, 0, 0, 0, 0, "R3");
      cyc(0, 0, 0, 0, 0, 0, "R3");
      cyc(0, 0, 0, 0, 0, 0, "R3");
      done = 1;
      summary();
      $finish;
   end
endmodule